// File: doc/BRIEF.md
# Approximate-LSB ripple carry adder

This block adds two unsigned N-bit operands with a ripple-carry chain that is split in two. The most significant M positions are built from ordinary full adders and are therefore exact, given the carry they receive. The remaining N-M low positions are built from a cheaper full-adder cell that is deliberately wrong for some input combinations. It saves logic and shortens the carry path through the low end of the word.

A parameter chooses one of three cheap cells, numbered 1 (coarsest) to 3 (finest). The carry leaving the topmost cheap cell enters the exact section, so low-end errors can reach the high end only through that single carry. The sum is captured in a register. The block suits datapaths that tolerate small, bounded errors in the low bits. Setting M equal to N gives an ordinary exact adder.

Top module: `apx_lsb_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum` becomes all zeros at that edge.
- R2: `sum` is registered. It changes only at a rising edge, to the result for the operands present at that edge, so the latency is one cycle.
- R3: With M equal to N, `sum` equals (`op_a` + `op_b`) modulo 2^N.
- R4: With KIND = 1, every low cell puts out sum = b and carry = a, and ignores its carry-in.
- R5: With KIND = 2, every low cell puts out carry = majority(a, b, cin) and sum = NOT carry.
- R6: With KIND = 3, every low cell puts out sum = a XOR b XOR cin and carry = (a AND b) OR (b AND cin).
- R7: The lowest cell receives a carry-in of 0. The bits N-1 down to N-M are the exact sum of the operands' high M bits plus the carry from the topmost low cell, so the high field minus the two operand high fields is 0 or 1 modulo 2^M.
- R8: With M = 0, all N bits come from low cells of the selected kind, and the carry-in of bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| sum | output | N | Registered approximate sum, modulo 2^N |

## Verification
The bench builds five 8-bit copies and sweeps all 65,536 operand pairs through them. Three copies have M = 3, one for each cell kind. One has M = 8, which makes it exact. One has M = 0, which makes the whole word approximate. Two 16-bit copies, with (M, kind) equal to (6, 3) and (10, 1), receive operands derived from the same sweep. The 8-bit sizes make an exhaustive sweep affordable. That exposes every carry pattern across the boundary between the low and high sections, including every case in which a wrong low carry changes the high field. The bench also prints the error count and the summed absolute error for each kind.

// File: rtl/apx_add_pkg.sv
package apx_add_pkg;

  localparam int unsigned KIND_COARSE = 1;
  localparam int unsigned KIND_MID    = 2;
  localparam int unsigned KIND_FINE   = 3;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/apx_exact_fa.sv
module apx_exact_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  import apx_add_pkg::*;

  assign s  = a ^ b ^ ci;
  assign co = maj3(a, b, ci);

endmodule

// File: rtl/apx_cheap_fa.sv
module apx_cheap_fa #(
  parameter int unsigned KIND = 3
) (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  import apx_add_pkg::*;

  generate
    if (KIND == KIND_COARSE) begin : g_coarse
      // The carry-in plays no part in this cell.
      logic unused_ci;
      assign unused_ci = ci;
      assign s  = b;
      assign co = a;
    end else if (KIND == KIND_MID) begin : g_mid
      logic c_int;
      assign c_int = maj3(a, b, ci);
      assign co    = c_int;
      assign s     = ~c_int;
    end else begin : g_fine
      assign s  = a ^ b ^ ci;
      assign co = (a & b) | (b & ci);
    end
  endgenerate

endmodule

// File: rtl/apx_ripple_core.sv
module apx_ripple_core #(
  parameter int unsigned N    = 8,
  parameter int unsigned M    = 3,
  parameter int unsigned KIND = 3
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] s,
  output logic         cout
);
  localparam int unsigned LOW_W = N - M;

  logic [N:0] carry;
  assign carry[0] = 1'b0;
  assign cout     = carry[N];

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < LOW_W) begin : g_low
      apx_cheap_fa #(.KIND(KIND)) u_cell (
        .a (a[i]),
        .b (b[i]),
        .ci(carry[i]),
        .s (s[i]),
        .co(carry[i+1])
      );
    end else begin : g_high
      apx_exact_fa u_cell (
        .a (a[i]),
        .b (b[i]),
        .ci(carry[i]),
        .s (s[i]),
        .co(carry[i+1])
      );
    end
  end

endmodule

// File: rtl/apx_lsb_adder.sv
module apx_lsb_adder #(
  parameter int unsigned N    = 8,
  parameter int unsigned M    = 3,
  parameter int unsigned KIND = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N-1:0] sum
);
  logic [N-1:0] sum_d;
  logic         unused_cout;

  apx_ripple_core #(.N(N), .M(M), .KIND(KIND)) u_core (
    .a   (op_a),
    .b   (op_b),
    .s   (sum_d),
    .cout(unused_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) sum <= '0;
    else     sum <= sum_d;
  end

endmodule

// File: rtl/apx_lsb_adder_chk.sv
module apx_lsb_adder_chk #(
  parameter int unsigned N    = 8,
  parameter int unsigned M    = 3,
  parameter int unsigned KIND = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic [N-1:0] sum
);
  logic         prev_ok = 1'b0;
  logic [N-1:0] pa = '0;
  logic [N-1:0] pb = '0;

  always_ff @(posedge clk) begin
    prev_ok <= !rst;
    pa      <= op_a;
    pb      <= op_b;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sum == '0));

  if (M == N) begin : g_exact
    logic [N-1:0] ref_sum;
    assign ref_sum = pa + pb;
    // R3
    exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
      prev_ok |-> (sum == ref_sum));
  end

  if (M > 0 && M < N) begin : g_split
    logic [M-1:0] hi_gap;
    assign hi_gap = sum[N-1:N-M] - pa[N-1:N-M] - pb[N-1:N-M];
    // R7
    high_carry_chk: assert property (@(posedge clk) disable iff (rst)
      prev_ok |-> (hi_gap <= 1));
  end

  if (M < N) begin : g_bit0
    if (KIND == 1) begin : g_k1
      // R4
      coarse_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok |-> (sum[0] == pb[0]));
    end else if (KIND == 2) begin : g_k2
      // R5
      mid_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok |-> (sum[0] == !(pa[0] && pb[0])));
    end else begin : g_k3
      // R6
      fine_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok |-> (sum[0] == (pa[0] ^ pb[0])));
    end
  end

endmodule

bind apx_lsb_adder apx_lsb_adder_chk #(.N(N), .M(M), .KIND(KIND)) u_chk (
  .clk (clk),
  .rst (rst),
  .op_a(op_a),
  .op_b(op_b),
  .sum (sum)
);

// File: tb/apx_lsb_adder_bench.sv
`timescale 1ns/1ps
module apx_lsb_adder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16, b16;
  assign a16 = {b8 ^ 8'hA5, a8};
  assign b16 = {a8, b8 ^ 8'h3C};

  logic [7:0]  s_k1, s_k2, s_k3, s_ex, s_all;
  logic [15:0] s_w63, s_w101;

  apx_lsb_adder #(.N(8), .M(3), .KIND(1)) u_apx_lsb_adder_k1 (.clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sum(s_k1));
  apx_lsb_adder #(.N(8), .M(3), .KIND(2)) u_apx_lsb_adder_k2 (.clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sum(s_k2));
  apx_lsb_adder #(.N(8), .M(3), .KIND(3)) u_apx_lsb_adder    (.clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sum(s_k3));
  apx_lsb_adder #(.N(8), .M(8), .KIND(3)) u_apx_lsb_adder_ex (.clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sum(s_ex));
  apx_lsb_adder #(.N(8), .M(0), .KIND(2)) u_apx_lsb_adder_m0 (.clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sum(s_all));
  apx_lsb_adder #(.N(16), .M(6), .KIND(3))  u_apx_lsb_adder_w63  (.clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .sum(s_w63));
  apx_lsb_adder #(.N(16), .M(10), .KIND(1)) u_apx_lsb_adder_w101 (.clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .sum(s_w101));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int err_cnt[1:3];
  longint err_sum[1:3];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-level reference built from the cell equations in the requirements.
  function automatic logic [15:0] model(input int n, input int m, input int kind,
                                        input logic [15:0] a, input logic [15:0] b);
    logic [15:0] s;
    logic c, co, ai, bi;
    s = '0;
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      ai = a[i];
      bi = b[i];
      if (i < n - m) begin
        case (kind)
          1: begin s[i] = bi; co = ai; end
          2: begin co = (ai & bi) | (ai & c) | (bi & c); s[i] = ~co; end
          default: begin s[i] = ai ^ bi ^ c; co = (ai & bi) | (bi & c); end
        endcase
      end else begin
        s[i] = ai ^ bi ^ c;
        co = (ai & bi) | (ai & c) | (bi & c);
      end
      c = co;
    end
    return s;
  endfunction

  task automatic note_err(input int kind, input logic [7:0] act, input logic [7:0] pa, input logic [7:0] pb);
    int e;
    e = int'(act) - int'((pa + pb) & 8'hFF);
    if (e != 0) err_cnt[kind]++;
    err_sum[kind] += (e < 0) ? -e : e;
  endtask

  task automatic check_all(input logic [7:0] pa, input logic [7:0] pb);
    logic [15:0] pa16, pb16;
    logic [2:0]  gap;
    pa16 = {pb ^ 8'hA5, pa};
    pb16 = {pa, pb ^ 8'h3C};
    check("R4", {8'h0, s_k1}, model(8, 3, 1, {8'h0, pa}, {8'h0, pb}));
    check("R5", {8'h0, s_k2}, model(8, 3, 2, {8'h0, pa}, {8'h0, pb}));
    check("R6", {8'h0, s_k3}, model(8, 3, 3, {8'h0, pa}, {8'h0, pb}));
    check("R3", {8'h0, s_ex}, {8'h0, 8'((pa + pb) & 8'hFF)});
    check("R8", {8'h0, s_all}, model(8, 0, 2, {8'h0, pa}, {8'h0, pb}));
    gap = s_k3[7:5] - pa[7:5] - pb[7:5];
    check("R7", {13'h0, gap > 3'd1}, 16'h0);
    check("R7", s_w63,  model(16, 6, 3, pa16, pb16));
    check("R7", s_w101, model(16, 10, 1, pa16, pb16));
    note_err(1, s_k1, pa, pb);
    note_err(2, s_k2, pa, pb);
    note_err(3, s_k3, pa, pb);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pa, pb;
    for (int k = 1; k <= 3; k++) begin err_cnt[k] = 0; err_sum[k] = 0; end
    a8 = 8'hFF; b8 = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {8'h0, s_k3}, 16'h0);
    check("R1", {8'h0, s_ex}, 16'h0);
    check("R1", s_w101, 16'h0);
    rst = 1'b0;

    // R2: one-cycle latency, output holds between edges
    a8 = 8'd5; b8 = 8'd9;
    @(negedge clk);
    check("R2", {8'h0, s_ex}, 16'd14);
    a8 = 8'd100; b8 = 8'd27;
    #1;
    check("R2", {8'h0, s_ex}, 16'd14);
    @(negedge clk);
    check("R2", {8'h0, s_ex}, 16'd127);

    // Exhaustive sweep
    pa = '0; pb = '0;
    for (int i = 0; i < 65536; i++) begin
      a8 = i[7:0];
      b8 = i[15:8];
      pa = a8; pb = b8;
      @(negedge clk);
      check_all(pa, pb);
    end

    for (int k = 1; k <= 3; k++)
      $display("kind %0d: wrong results %0d, summed |error| %0d", k, err_cnt[k], err_sum[k]);

    // R1: reset in mid-run with live operands
    a8 = 8'hC3; b8 = 8'h5A;
    rst = 1'b1;
    @(negedge clk);
    check("R1", {8'h0, s_k1}, 16'h0);
    check("R1", {8'h0, s_all}, 16'h0);
    check("R1", s_w63, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check_all(8'hC3, 8'h5A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule